// File: doc/BRIEF.md
# Double-Buffered Video Capture Controller

This block takes an 8-bit digitized video stream and stores it in two external asynchronous SRAMs. The stream arrives as 4:2:2 samples on one pixel clock. Each byte is one of Cb, Y, Cr, Y, in that order. A line-valid strobe and a field-valid level frame the active picture. On the fly, the block shrinks each full-size frame to CIF size in 4:1:1 order. It does this by keeping every other luma sample and one Cb/Cr pair per four kept luma samples, and by storing only one field out of each pair. The samples of a frame are written back to back from address zero into whichever SRAM the controller currently owns. The block never reads either memory.

Each SRAM has its own address, data, chip-select and write-enable lines. Two isolator controls decide which side owns each SRAM. The memory being filled is tied to the controller, and the other memory is handed to a DSP. When a stored frame is complete and every queued write has reached the memory, the block pulses an interrupt toward the DSP. The two memories then trade roles at the next field-valid rising edge. Because of this, a frame that was cut short is never handed over. Its memory is simply refilled by the next stored field.

Writes use a two-cycle sequence: one setup cycle with chip select low, then one strobe cycle with write enable also low. A four-entry queue absorbs the burst of three back-to-back kept bytes at the start of each 16-byte group.

Top module: `pingpong_capture_ctrl`

## Requirements
- R1: After reset, SRAM A is the write target: `iso_a_o`=1, `iso_b_o`=0, all chip selects and write enables are high, both address buses are 0, and `dsp_irq_o` is 0.
- R2: Bytes are stored only while `href_i` and `vref_i` are both high and the field is a stored field. Stored fields are the first field after reset and then every second field, where a field starts at each rising edge of `vref_i`. Bytes on lines outside this are not written to either SRAM.
- R3: Within a line, byte index i counts from 0 at the first `href_i`-high cycle. In each 16-byte group g, the bytes at positions 0, 1, 2, 5, 9 and 13 are written in that order (Cb, Y, Cr, Y, Y, Y). Only groups g < OUT_W/4 are used. The byte of slot s of group g on stored line n goes to address n*(OUT_W*3/2) + g*6 + s.
- R4: At most OUT_LINES lines are stored per frame. Further lines of the same field are ignored.
- R5: Exactly one of `iso_a_o` and `iso_b_o` is high at all times. The high one marks the SRAM the controller is writing.
- R6: Each write has one setup cycle (chip select low, write enable high) followed by exactly one cycle with write enable low. Address and data are the same in both cycles.
- R7: A write enable is low only while the chip select of the same SRAM is low, and the two chip selects are never low together.
- R8: After OUT_LINES lines have been stored and all their writes are done, `dsp_irq_o` is high for exactly IRQ_LEN cycles, once per stored frame.
- R9: The target SRAM swaps only at the first rising edge of `vref_i` after a completed frame. This includes a rising edge that falls in the very cycle in which completion is detected.
- R10: A stored field that ends with fewer than OUT_LINES lines raises no interrupt and causes no swap. The next stored field rewrites the same SRAM.
- R11: The write address restarts at 0 for every stored frame, so the first sample of each frame lands at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_i | input | 8 | Incoming 4:2:2 video byte |
| href_i | input | 1 | Line-valid level |
| vref_i | input | 1 | Field-valid level, a rising edge starts a field |
| sram_a_data_o | output | 8 | Write data for SRAM A |
| sram_a_addr_o | output | 19 | Address for SRAM A |
| sram_a_ce_n_o | output | 1 | Chip select of SRAM A, active low |
| sram_a_we_n_o | output | 1 | Write enable of SRAM A, active low |
| sram_b_data_o | output | 8 | Write data for SRAM B |
| sram_b_addr_o | output | 19 | Address for SRAM B |
| sram_b_ce_n_o | output | 1 | Chip select of SRAM B, active low |
| sram_b_we_n_o | output | 1 | Write enable of SRAM B, active low |
| iso_a_o | output | 1 | 1: SRAM A tied to the controller, 0: tied to the DSP |
| iso_b_o | output | 1 | 1: SRAM B tied to the controller, 0: tied to the DSP |
| dsp_irq_o | output | 1 | Frame-ready interrupt pulse |

## Verification
Two events can fall on the same clock edge: the detection that a frame is complete, which launches the interrupt, and the field-valid rising edge that performs the buffer swap. The bench provokes this by dropping `href_i` and `vref_i` together at the end of the last stored line, then raising `vref_i` on the very next cycle, so the rising edge arrives at the edge where completion is first seen. It judges the result from three things: the isolator controls must already have swapped during the following field, the interrupt must still be exactly IRQ_LEN cycles wide, and the next stored frame must land in the other SRAM starting at address 0.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

    // Fixed geometry of the external memories and of the 4:2:2 byte groups.
    localparam int SRAM_AW     = 19;
    localparam int PIX_W       = 8;
    localparam int GROUP_BYTES = 16;
    localparam int GROUP_SLOTS = 6;

    typedef enum logic [1:0] {
        WR_IDLE   = 2'd0,
        WR_SETUP  = 2'd1,
        WR_STROBE = 2'd2
    } wr_state_e;

    typedef struct packed {
        logic               ce_n;
        logic               we_n;
        logic [SRAM_AW-1:0] addr;
        logic [PIX_W-1:0]   data;
    } sram_port_t;

    // Positions inside a 16-byte group (Cb Y Cr Y ...) that survive
    // decimation: Cb0, Y0, Cr0, Y2, Y4, Y6. They arrive in storage order.
    function automatic logic slot_kept(input logic [3:0] pos);
        return (pos == 4'd0) || (pos == 4'd1) || (pos == 4'd2) ||
               (pos == 4'd5) || (pos == 4'd9) || (pos == 4'd13);
    endfunction

endpackage

// File: rtl/ppc_sampler.sv
module ppc_sampler
    import ppc_pkg::*;
#(
    parameter int IN_W      = 720,
    parameter int OUT_W     = 352,
    parameter int OUT_LINES = 288
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] pix_i,
    input  logic             href_i,
    input  logic             vref_i,
    output logic             push_o,
    output logic [PIX_W-1:0] push_data_o,
    output logic             vref_rise_o,
    output logic             lines_full_o
);

    localparam int LINE_BYTES  = 2 * IN_W;
    localparam int KEEP_GROUPS = OUT_W / 4;
    localparam int BCW         = $clog2(LINE_BYTES + 1);
    localparam int LCW         = $clog2(OUT_LINES + 1);
    localparam int GRP_SH      = $clog2(GROUP_BYTES);

    localparam logic [BCW-1:0] BYTE_MAX  = BCW'(LINE_BYTES);
    localparam logic [BCW-1:0] GROUP_LIM = BCW'(KEEP_GROUPS);
    localparam logic [LCW-1:0] LINE_LIM  = LCW'(OUT_LINES);

    logic           href_q;
    logic           vref_q;
    logic           odd_q;
    logic           keep_q;
    logic [BCW-1:0] byte_cnt;
    logic [LCW-1:0] line_cnt;

    logic [BCW-1:0] group;
    logic [3:0]     pos;
    logic           room;
    logic           take;
    logic           line_end;

    always_comb begin
        group       = byte_cnt >> GRP_SH;
        pos         = byte_cnt[3:0];
        room        = keep_q && (line_cnt < LINE_LIM);
        take        = room && vref_i && href_i && (group < GROUP_LIM) && slot_kept(pos);
        // the line is counted against the field level seen on the previous edge
        line_end    = room && vref_q && href_q && !href_i;
        vref_rise_o = vref_i && !vref_q;
    end

    assign lines_full_o = keep_q && (line_cnt == LINE_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            href_q      <= 1'b0;
            vref_q      <= 1'b0;
            odd_q       <= 1'b0;
            keep_q      <= 1'b0;
            byte_cnt    <= '0;
            line_cnt    <= '0;
            push_o      <= 1'b0;
            push_data_o <= '0;
        end else begin
            href_q      <= href_i;
            vref_q      <= vref_i;
            push_o      <= take && !vref_rise_o;
            push_data_o <= pix_i;
            if (vref_rise_o) begin
                odd_q    <= !odd_q;
                keep_q   <= !odd_q;
                line_cnt <= '0;
                byte_cnt <= '0;
            end else begin
                if (!href_i) begin
                    byte_cnt <= '0;
                end else if (byte_cnt != BYTE_MAX) begin
                    byte_cnt <= byte_cnt + 1'b1;
                end
                if (line_end) begin
                    line_cnt <= line_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ppc_fifo.sv
module ppc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] data_o,
    output logic         empty_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [CW-1:0] cnt;
    logic          do_push;
    logic          do_pop;

    assign do_push = push_i && (cnt != FULLC);
    assign do_pop  = pop_i && (cnt != '0);
    assign data_o  = mem[rp];
    assign empty_o = (cnt == '0);

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                wp <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (do_pop) begin
                rp <= (rp == LAST) ? '0 : rp + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/ppc_writer.sv
module ppc_writer
    import ppc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   fifo_empty_i,
    input  logic [PIX_W-1:0]       fifo_data_i,
    input  logic                   bank_i,
    input  logic                   addr_clr_i,
    output logic                   pop_o,
    output logic                   busy_o,
    output sram_port_t [1:0]       port_o
);

    wr_state_e          state;
    logic [SRAM_AW-1:0] addr_q;
    logic [PIX_W-1:0]   data_q;

    // A new byte is taken when idle or while the current strobe ends.
    assign pop_o  = !fifo_empty_i && (state != WR_SETUP);
    assign busy_o = (state != WR_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= WR_IDLE;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            case (state)
                WR_IDLE: begin
                    if (pop_o) begin
                        state  <= WR_SETUP;
                        data_q <= fifo_data_i;
                    end
                end
                WR_SETUP: begin
                    state <= WR_STROBE;
                end
                WR_STROBE: begin
                    if (pop_o) begin
                        state  <= WR_SETUP;
                        data_q <= fifo_data_i;
                    end else begin
                        state <= WR_IDLE;
                    end
                end
                default: state <= WR_IDLE;
            endcase
            if (addr_clr_i) begin
                addr_q <= '0;
            end else if (state == WR_STROBE) begin
                addr_q <= addr_q + 1'b1;
            end
        end
    end

    for (genvar b = 0; b < 2; b++) begin : g_port
        localparam logic MINE = 1'(b);
        sram_port_t p;
        always_comb begin
            p.ce_n = !((state != WR_IDLE) && (bank_i == MINE));
            p.we_n = !((state == WR_STROBE) && (bank_i == MINE));
            p.addr = (bank_i == MINE) ? addr_q : '0;
            p.data = (bank_i == MINE) ? data_q : '0;
        end
        assign port_o[b] = p;
    end

endmodule

// File: rtl/ppc_bank_ctrl.sv
module ppc_bank_ctrl #(
    parameter int IRQ_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic vref_rise_i,
    input  logic lines_full_i,
    input  logic drained_i,
    output logic bank_o,
    output logic irq_o
);

    localparam int ICW = $clog2(IRQ_LEN + 1);
    localparam logic [ICW-1:0] IRQ_LOAD = ICW'(IRQ_LEN);

    logic           fired_q;
    logic           pend_q;
    logic           bank_q;
    logic [ICW-1:0] irq_cnt;
    logic           done_evt;

    assign done_evt = lines_full_i && drained_i && !fired_q;
    assign bank_o   = bank_q;
    assign irq_o    = (irq_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            fired_q <= 1'b0;
            pend_q  <= 1'b0;
            bank_q  <= 1'b0;
            irq_cnt <= '0;
        end else begin
            if (done_evt) begin
                irq_cnt <= IRQ_LOAD;
            end else if (irq_cnt != '0) begin
                irq_cnt <= irq_cnt - 1'b1;
            end
            if (vref_rise_i) begin
                fired_q <= 1'b0;
                pend_q  <= 1'b0;
                if (pend_q || done_evt) begin
                    bank_q <= !bank_q;
                end
            end else if (done_evt) begin
                fired_q <= 1'b1;
                pend_q  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pingpong_capture_ctrl.sv
module pingpong_capture_ctrl
    import ppc_pkg::*;
#(
    parameter int IN_W       = 720,
    parameter int OUT_W      = 352,
    parameter int OUT_LINES  = 288,
    parameter int IRQ_LEN    = 4,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PIX_W-1:0]     pix_i,
    input  logic                 href_i,
    input  logic                 vref_i,
    output logic [PIX_W-1:0]     sram_a_data_o,
    output logic [SRAM_AW-1:0]   sram_a_addr_o,
    output logic                 sram_a_ce_n_o,
    output logic                 sram_a_we_n_o,
    output logic [PIX_W-1:0]     sram_b_data_o,
    output logic [SRAM_AW-1:0]   sram_b_addr_o,
    output logic                 sram_b_ce_n_o,
    output logic                 sram_b_we_n_o,
    output logic                 iso_a_o,
    output logic                 iso_b_o,
    output logic                 dsp_irq_o
);

    logic             push;
    logic [PIX_W-1:0] push_data;
    logic             vref_rise;
    logic             lines_full;
    logic [PIX_W-1:0] fifo_data;
    logic             fifo_empty;
    logic             pop;
    logic             busy;
    logic             bank;
    sram_port_t [1:0] ports;

    ppc_sampler #(
        .IN_W      (IN_W),
        .OUT_W     (OUT_W),
        .OUT_LINES (OUT_LINES)
    ) u_sampler (
        .clk          (clk),
        .rst          (rst),
        .pix_i        (pix_i),
        .href_i       (href_i),
        .vref_i       (vref_i),
        .push_o       (push),
        .push_data_o  (push_data),
        .vref_rise_o  (vref_rise),
        .lines_full_o (lines_full)
    );

    ppc_fifo #(
        .W     (PIX_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push),
        .data_i  (push_data),
        .pop_i   (pop),
        .data_o  (fifo_data),
        .empty_o (fifo_empty)
    );

    ppc_writer u_writer (
        .clk          (clk),
        .rst          (rst),
        .fifo_empty_i (fifo_empty),
        .fifo_data_i  (fifo_data),
        .bank_i       (bank),
        .addr_clr_i   (vref_rise),
        .pop_o        (pop),
        .busy_o       (busy),
        .port_o       (ports)
    );

    ppc_bank_ctrl #(
        .IRQ_LEN (IRQ_LEN)
    ) u_bank (
        .clk          (clk),
        .rst          (rst),
        .vref_rise_i  (vref_rise),
        .lines_full_i (lines_full),
        .drained_i    (fifo_empty && !busy && !push),
        .bank_o       (bank),
        .irq_o        (dsp_irq_o)
    );

    assign sram_a_data_o = ports[0].data;
    assign sram_a_addr_o = ports[0].addr;
    assign sram_a_ce_n_o = ports[0].ce_n;
    assign sram_a_we_n_o = ports[0].we_n;
    assign sram_b_data_o = ports[1].data;
    assign sram_b_addr_o = ports[1].addr;
    assign sram_b_ce_n_o = ports[1].ce_n;
    assign sram_b_we_n_o = ports[1].we_n;
    assign iso_a_o       = !bank;
    assign iso_b_o       = bank;

endmodule

// File: rtl/ppc_chk.sv
module ppc_chk #(
    parameter int IRQ_LEN = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        vref_i,
    input logic [7:0]  sram_a_data_o,
    input logic [18:0] sram_a_addr_o,
    input logic        sram_a_ce_n_o,
    input logic        sram_a_we_n_o,
    input logic [7:0]  sram_b_data_o,
    input logic [18:0] sram_b_addr_o,
    input logic        sram_b_ce_n_o,
    input logic        sram_b_we_n_o,
    input logic        iso_a_o,
    input logic        iso_b_o,
    input logic        dsp_irq_o
);

    localparam int ICW = $clog2(IRQ_LEN + 2);

    logic           vref_d;
    logic [ICW-1:0] irq_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            vref_d  <= 1'b0;
            irq_run <= '0;
        end else begin
            vref_d  <= vref_i;
            irq_run <= dsp_irq_o ? irq_run + 1'b1 : '0;
        end
    end

    // R5
    iso_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        iso_a_o != iso_b_o);

    // R7
    a_we_in_ce_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_a_we_n_o |-> !sram_a_ce_n_o);

    // R7
    b_we_in_ce_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_b_we_n_o |-> !sram_b_ce_n_o);

    // R7
    single_select_chk: assert property (@(posedge clk) disable iff (rst)
        sram_a_ce_n_o || sram_b_ce_n_o);

    // R6
    a_setup_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_a_we_n_o |-> ($past(!sram_a_ce_n_o) && $past(sram_a_we_n_o) &&
                            $stable(sram_a_addr_o) && $stable(sram_a_data_o)));

    // R6
    b_setup_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_b_we_n_o |-> ($past(!sram_b_ce_n_o) && $past(sram_b_we_n_o) &&
                            $stable(sram_b_addr_o) && $stable(sram_b_data_o)));

    // R6
    a_release_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_a_we_n_o |=> sram_a_we_n_o);

    // R6
    b_release_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_b_we_n_o |=> sram_b_we_n_o);

    // R8
    irq_width_chk: assert property (@(posedge clk) disable iff (rst)
        (!dsp_irq_o && $past(dsp_irq_o)) |-> (int'(irq_run) == IRQ_LEN));

    // R8
    irq_cap_chk: assert property (@(posedge clk) disable iff (rst)
        dsp_irq_o |-> (int'(irq_run) < IRQ_LEN));

    // R9
    swap_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (iso_a_o != $past(iso_a_o)) |-> ($past(vref_i) && !$past(vref_d)));

endmodule

bind pingpong_capture_ctrl ppc_chk #(
    .IRQ_LEN (IRQ_LEN)
) u_ppc_chk (
    .clk           (clk),
    .rst           (rst),
    .vref_i        (vref_i),
    .sram_a_data_o (sram_a_data_o),
    .sram_a_addr_o (sram_a_addr_o),
    .sram_a_ce_n_o (sram_a_ce_n_o),
    .sram_a_we_n_o (sram_a_we_n_o),
    .sram_b_data_o (sram_b_data_o),
    .sram_b_addr_o (sram_b_addr_o),
    .sram_b_ce_n_o (sram_b_ce_n_o),
    .sram_b_we_n_o (sram_b_we_n_o),
    .iso_a_o       (iso_a_o),
    .iso_b_o       (iso_b_o),
    .dsp_irq_o     (dsp_irq_o)
);

// File: tb/pingpong_capture_ctrl_test.sv
module pingpong_capture_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int IN_W       = 24;
    localparam int OUT_W      = 8;
    localparam int OUT_LINES  = 3;
    localparam int IRQ_LEN    = 4;
    localparam int LINE_BYTES = 2 * IN_W;
    localparam int STRIDE     = OUT_W * 3 / 2;
    localparam int FRAME_WR   = OUT_LINES * STRIDE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pix = 8'h00;
    logic        href = 1'b0;
    logic        vref = 1'b0;
    logic [7:0]  a_data, b_data;
    logic [18:0] a_addr, b_addr;
    logic        a_ce_n, a_we_n, b_ce_n, b_we_n;
    logic        iso_a, iso_b, irq;

    int n_checks = 0;
    int n_err    = 0;

    logic [7:0] mem_a [64];
    logic [7:0] mem_b [64];
    int wr_a = 0;
    int wr_b = 0;
    int irq_run = 0;
    int irq_last = 0;
    int irq_pulses = 0;
    int proto_err = 0;
    logic prev_a_ok = 1'b0;
    logic prev_b_ok = 1'b0;
    logic [18:0] prev_a_addr = '0;
    logic [18:0] prev_b_addr = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pingpong_capture_ctrl #(
        .IN_W      (IN_W),
        .OUT_W     (OUT_W),
        .OUT_LINES (OUT_LINES),
        .IRQ_LEN   (IRQ_LEN)
    ) uut (
        .clk           (clk),
        .rst           (rst),
        .pix_i         (pix),
        .href_i        (href),
        .vref_i        (vref),
        .sram_a_data_o (a_data),
        .sram_a_addr_o (a_addr),
        .sram_a_ce_n_o (a_ce_n),
        .sram_a_we_n_o (a_we_n),
        .sram_b_data_o (b_data),
        .sram_b_addr_o (b_addr),
        .sram_b_ce_n_o (b_ce_n),
        .sram_b_we_n_o (b_we_n),
        .iso_a_o       (iso_a),
        .iso_b_o       (iso_b),
        .dsp_irq_o     (irq)
    );

    // Memory model and protocol observer, sampled away from the rising edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (!a_ce_n && !a_we_n) begin
                if (a_addr < 19'd64) mem_a[a_addr[5:0]] = a_data;
                wr_a++;
                if (!prev_a_ok || prev_a_addr != a_addr) proto_err++;
            end
            if (!b_ce_n && !b_we_n) begin
                if (b_addr < 19'd64) mem_b[b_addr[5:0]] = b_data;
                wr_b++;
                if (!prev_b_ok || prev_b_addr != b_addr) proto_err++;
            end
            if ((!a_we_n && a_ce_n) || (!b_we_n && b_ce_n) || (!a_ce_n && !b_ce_n)) proto_err++;
            prev_a_ok   = !a_ce_n && a_we_n;
            prev_b_ok   = !b_ce_n && b_we_n;
            prev_a_addr = a_addr;
            prev_b_addr = b_addr;
            if (irq) begin
                irq_run++;
            end else if (irq_run != 0) begin
                irq_last = irq_run;
                irq_pulses++;
                irq_run = 0;
            end
        end
    end

    function automatic logic [7:0] pat(int tag, int line, int i);
        return 8'((tag * 53 + line * 29 + i * 7 + 1) & 255);
    endfunction

    function automatic int slot_pos(int s);
        case (s)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 5;
            4: return 9;
            default: return 13;
        endcase
    endfunction

    task automatic chk_eq(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_frame(string req, bit use_b, int tag);
        int bad = 0;
        for (int n = 0; n < OUT_LINES; n++) begin
            for (int k = 0; k < STRIDE; k++) begin
                int idx = (k / 6) * 16 + slot_pos(k % 6);
                logic [7:0] got = use_b ? mem_b[n * STRIDE + k] : mem_a[n * STRIDE + k];
                if (got !== pat(tag, n, idx)) bad++;
            end
        end
        chk_eq(req, bad, 0);
    endtask

    task automatic open_field();
        @(negedge clk);
        vref = 1'b0;
        repeat (4) @(negedge clk);
        vref = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic close_field();
        @(negedge clk);
        vref = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    // quick: the last line ends together with vref, which rises one cycle later
    task automatic send_lines(int tag, int nlines, bit quick);
        for (int l = 0; l < nlines; l++) begin
            for (int i = 0; i < LINE_BYTES; i++) begin
                @(negedge clk);
                href = 1'b1;
                pix  = pat(tag, l, i);
            end
            @(negedge clk);
            href = 1'b0;
            pix  = 8'hA5;
            if (quick && l == nlines - 1) begin
                vref = 1'b0;
                @(negedge clk);
                vref = 1'b1;
            end else begin
                repeat (6) @(negedge clk);
            end
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 iso_a", int'(iso_a), 1);
        chk_eq("R1 iso_b", int'(iso_b), 0);
        chk_eq("R1 selects and enables high", int'({a_ce_n, a_we_n, b_ce_n, b_we_n}), 15);
        chk_eq("R1 addresses", int'(a_addr) + int'(b_addr), 0);
        chk_eq("R1 irq", int'(irq), 0);

        // R2 a line while the field level is low is not stored
        send_lines(99, 1, 1'b0);
        chk_eq("R2 no writes outside field", wr_a + wr_b, 0);

        // frame tag 1 into A, with one surplus line
        open_field();
        send_lines(1, OUT_LINES + 1, 1'b0);
        close_field();
        chk_eq("R4 writes to A", wr_a, FRAME_WR);
        chk_eq("R2 writes to B", wr_b, 0);
        chk_frame("R3 contents of A tag 1", 1'b0, 1);
        chk_eq("R8 irq pulses", irq_pulses, 1);
        chk_eq("R8 irq width", irq_last, IRQ_LEN);
        chk_eq("R9 swap deferred", int'(iso_a), 1);

        // skipped field; its rising edge performs the swap
        open_field();
        chk_eq("R9 iso_b after edge", int'(iso_b), 1);
        chk_eq("R5 iso_a after edge", int'(iso_a), 0);
        send_lines(2, OUT_LINES + 1, 1'b0);
        close_field();
        chk_eq("R2 skipped field A", wr_a, FRAME_WR);
        chk_eq("R2 skipped field B", wr_b, 0);

        // frame tag 3 into B; completion and next edge coincide
        open_field();
        send_lines(3, OUT_LINES, 1'b1);
        repeat (2) @(negedge clk);
        chk_eq("R9 coincident swap back to A", int'(iso_a), 1);
        send_lines(4, OUT_LINES, 1'b0);
        close_field();
        chk_eq("R11 writes to B", wr_b, FRAME_WR);
        chk_frame("R11 contents of B tag 3", 1'b1, 3);
        chk_eq("R2 A untouched", wr_a, FRAME_WR);
        chk_eq("R8 irq pulses coincident", irq_pulses, 2);
        chk_eq("R8 irq width coincident", irq_last, IRQ_LEN);

        // partial frame into A
        open_field();
        send_lines(5, OUT_LINES - 1, 1'b0);
        close_field();
        chk_eq("R10 partial writes", wr_a, FRAME_WR + (OUT_LINES - 1) * STRIDE);
        chk_eq("R10 no irq", irq_pulses, 2);
        open_field();
        chk_eq("R10 no swap", int'(iso_a), 1);
        send_lines(6, OUT_LINES, 1'b0);
        close_field();

        // full frame rewrites A from address 0
        open_field();
        send_lines(7, OUT_LINES, 1'b0);
        close_field();
        chk_eq("R10 refill count", wr_a, 2 * FRAME_WR + (OUT_LINES - 1) * STRIDE);
        chk_frame("R11 contents of A tag 7", 1'b0, 7);
        chk_eq("R8 irq pulses refill", irq_pulses, 3);
        open_field();
        chk_eq("R9 swap after refill", int'(iso_b), 1);
        close_field();

        chk_eq("R6 R7 write protocol violations", proto_err, 0);
        finish_run();
    end

endmodule